// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Rotator

This block computes the cosine and the sine of an angle with the circular rotation form of CORDIC. It uses adders, arithmetic shifters and a small table of arctangents, and it has no multiplier. Three registers hold the vector's x and y coordinates and the residual angle. Each clock performs one micro-rotation. The direction of a micro-rotation is set by the sign of the residual angle. The gain that the rotations build up is cancelled ahead of time: the x register starts at the reciprocal of that gain, so the final coordinates are the cosine and the sine with no correction afterwards.

A caller drives an angle and pulses a start strobe. A fixed number of clocks later the done flag rises, with the results on the outputs. Results and flag then hold until the caller issues the next start. The number of iterations equals the output width, and the accuracy grows by about one bit per iteration.

Top module: `cordic_rot`

## Requirements
- R1: While reset is asserted and after its release, before any start, done_o is low and cos_o and sin_o are zero.
- R2: A start_i sampled high while no computation is running is accepted on that edge. done_o then rises exactly W rising clock edges later, one micro-rotation per edge.
- R3: angle_i is signed two's complement and a full turn equals 2^AW, so code c stands for c*360/2^AW degrees. Valid inputs lie within ±99 degrees. cos_o and sin_o are signed two's complement with 1.0 equal to 2^(W-2), and each is within 2 LSB of the rounded exact value.
- R4: While done_o is high and start_i stays low, done_o stays high and cos_o and sin_o keep their values.
- R5: While a computation runs, start_i and angle_i are ignored. The running result and its latency are unaffected.
- R6: A start_i sampled high while done_o is high begins a new computation, and done_o is low after that edge.
- R7: Whenever done_o is high, the magnitudes of cos_o and sin_o do not exceed 2^(W-2)+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a computation when idle or finished |
| angle_i | input | AW | Signed angle, full turn = 2^AW |
| cos_o | output | W | Signed cosine, 1.0 = 2^(W-2) |
| sin_o | output | W | Signed sine, 1.0 = 2^(W-2) |
| done_o | output | 1 | Result valid, held until the next start |

## Verification
The bench builds the block with W = 16 and AW = 16. This gives sixteen micro-rotations, six guard bits on the coordinates and the residual angle, and an angle step of 360/65536 degrees. At these sizes ±45 and ±90 degrees are exact codes and ±30 degrees is within a fraction of a code, so the 2 LSB bound of R3 can be checked at zero, at the octant and quadrant points, and at both ends of the ±99 degree range. The 16-clock latency leaves enough busy cycles to inject a stray start and angle in the middle of a run.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

  typedef logic [127:0] wide_t;

  // round(atan(2^-idx) / (2*pi) * 2^aw)
  function automatic logic [63:0] atan_turns(input int unsigned idx, input int unsigned aw);
    wide_t acc;
    wide_t term;
    wide_t prod;
    int    sh;
    if (idx == 0) return 64'(wide_t'(1) << (aw - 3));
    acc = '0;
    // power series in Q60, converges for 2^-idx <= 1/2
    for (int k = 0; k < 40; k++) begin
      sh = 60 - int'(idx) * (2 * k + 1);
      if (sh >= 0) begin
        term = (wide_t'(1) << sh) / wide_t'(2 * k + 1);
        if (k % 2 == 0) acc = acc + term;
        else            acc = acc - term;
      end
    end
    // Q30 radians times 1/(2*pi) in Q32 gives turns in Q62
    prod = (acc >> 30) * wide_t'(64'd683565276);
    prod = (prod + (wide_t'(1) << (61 - aw))) >> (62 - aw);
    return prod[63:0];
  endfunction

  // round(2^frac / prod_{i<n} sqrt(1 + 2^-2i))
  function automatic logic [63:0] inv_gain(input int unsigned n, input int unsigned frac);
    wide_t p;
    wide_t num;
    wide_t root;
    wide_t trial;
    wide_t q;
    p = wide_t'(1) << 60;
    for (int i = 0; i < int'(n); i++) p = p + (p >> (2 * i));
    num  = p << 60;
    root = '0;
    for (int b = 63; b >= 0; b--) begin
      trial = root | (wide_t'(1) << b);
      if (trial * trial <= num) root = trial;
    end
    q = ((wide_t'(1) << (60 + frac)) + (root >> 1)) / root;
    return q[63:0];
  endfunction

endpackage

// File: rtl/cordic_rot_atab.sv
module cordic_rot_atab #(
  parameter int N  = 16,
  parameter int ZW = 23,
  parameter int TW = 22,
  localparam int CW = $clog2(N)
) (
  input  logic [CW-1:0] idx_i,
  output logic [ZW-1:0] atan_o
);
  import cordic_rot_pkg::*;

  logic [ZW-1:0] tab [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam logic [63:0] VAL = atan_turns(g, TW);
    assign tab[g] = VAL[ZW-1:0];
  end

  assign atan_o = tab[idx_i];

endmodule

// File: rtl/cordic_rot_step.sv
module cordic_rot_step #(
  parameter int IW = 22,
  parameter int ZW = 23,
  parameter int SW = 4
) (
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  input  logic        [SW-1:0] sh_i,
  input  logic        [ZW-1:0] atan_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  logic              ccw;
  logic signed [IW-1:0] x_sh;
  logic signed [IW-1:0] y_sh;

  assign ccw  = ~z_i[ZW-1];
  assign x_sh = x_i >>> sh_i;
  assign y_sh = y_i >>> sh_i;

  always_comb begin
    if (ccw) begin
      x_o = x_i - y_sh;
      y_o = y_i + x_sh;
      z_o = z_i - $signed(atan_i);
    end else begin
      x_o = x_i + y_sh;
      y_o = y_i - x_sh;
      z_o = z_i + $signed(atan_i);
    end
  end

endmodule

// File: rtl/cordic_rot_seq.sv
module cordic_rot_seq #(
  parameter int N = 16,
  localparam int CW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          load_o,
  output logic          step_o,
  output logic          last_o,
  output logic [CW-1:0] idx_o,
  output logic          done_o
);
  logic          busy_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q & (cnt_q == CW'(N - 1));
  assign idx_o  = cnt_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last_o) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cordic_rot_round.sv
module cordic_rot_round #(
  parameter int IW = 22,
  parameter int G  = 6,
  localparam int W = IW - G
) (
  input  logic signed [IW-1:0] val_i,
  output logic        [W-1:0]  val_o
);
  localparam logic signed [IW-1:0] HALF = IW'(1) << (G - 1);

  logic signed [IW-1:0] biased;

  assign biased = val_i + HALF;
  assign val_o  = W'(biased >>> G);

endmodule

// File: rtl/cordic_rot.sv
module cordic_rot #(
  parameter int W  = 16,
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] angle_i,
  output logic [W-1:0]  cos_o,
  output logic [W-1:0]  sin_o,
  output logic          done_o
);
  import cordic_rot_pkg::*;

  localparam int N_ITER = W;
  localparam int CW     = $clog2(N_ITER);
  localparam int G      = $clog2(W) + 2;
  localparam int IW     = W + G;
  localparam int XF     = W - 2 + G;
  localparam int ZG     = G;
  localparam int ZW     = AW + ZG + 1;
  localparam logic [63:0] X0_FULL = inv_gain(N_ITER, XF);
  localparam logic signed [IW-1:0] X0 = X0_FULL[IW-1:0];

  logic          load;
  logic          step;
  logic          last;
  logic [CW-1:0] idx;
  logic [ZW-1:0] atan;

  logic signed [IW-1:0] x_q, y_q;
  logic signed [ZW-1:0] z_q;
  logic signed [IW-1:0] x_nxt, y_nxt;
  logic signed [ZW-1:0] z_nxt;
  logic signed [ZW-1:0] z_init;
  logic [W-1:0] cos_r, sin_r;
  logic [W-1:0] cos_q, sin_q;

  cordic_rot_seq #(.N(N_ITER)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .idx_o  (idx),
    .done_o (done_o)
  );

  cordic_rot_atab #(.N(N_ITER), .ZW(ZW), .TW(AW + ZG)) u_atab (
    .idx_i (idx),
    .atan_o(atan)
  );

  cordic_rot_step #(.IW(IW), .ZW(ZW), .SW(CW)) u_step (
    .x_i   (x_q),
    .y_i   (y_q),
    .z_i   (z_q),
    .sh_i  (idx),
    .atan_i(atan),
    .x_o   (x_nxt),
    .y_o   (y_nxt),
    .z_o   (z_nxt)
  );

  cordic_rot_round #(.IW(IW), .G(G)) u_rnd_cos (
    .val_i(x_nxt),
    .val_o(cos_r)
  );

  cordic_rot_round #(.IW(IW), .G(G)) u_rnd_sin (
    .val_i(y_nxt),
    .val_o(sin_r)
  );

  // residual angle carries ZG extra fraction bits and one headroom bit
  assign z_init = {angle_i[AW-1], angle_i, {ZG{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      cos_q <= '0;
      sin_q <= '0;
    end else begin
      if (load) begin
        x_q <= X0;
        y_q <= '0;
        z_q <= z_init;
      end else if (step) begin
        x_q <= x_nxt;
        y_q <= y_nxt;
        z_q <= z_nxt;
      end
      if (last) begin
        cos_q <= cos_r;
        sin_q <= sin_r;
      end
    end
  end

  assign cos_o = cos_q;
  assign sin_o = sin_q;

endmodule

// File: rtl/cordic_rot_chk.sv
module cordic_rot_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         done_o,
  input logic [W-1:0] cos_o,
  input logic [W-1:0] sin_o
);
  localparam int LW  = $clog2(W) + 3;
  localparam int LIM = 2 ** (W - 2) + 2;

  logic          run_q;
  logic [LW-1:0] lat_q;

  // port-level model of an accepted run and its edge count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      lat_q <= '0;
    end else if (start_i && (!run_q || done_o)) begin
      run_q <= 1'b1;
      lat_q <= '0;
    end else if (run_q && done_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R2, and R5: a stray start in mid-run must not move the finish
  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (run_q && lat_q == LW'(W)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(cos_o) && $stable(sin_o)));

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> !done_o);

  p_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'($signed(cos_o)) <= LIM && int'($signed(cos_o)) >= -LIM &&
                int'($signed(sin_o)) <= LIM && int'($signed(sin_o)) >= -LIM));

endmodule

bind cordic_rot cordic_rot_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .done_o (done_o),
  .cos_o  (cos_o),
  .sin_o  (sin_o)
);

// File: tb/cordic_rot_tb.sv
`timescale 1ns/1ps
module cordic_rot_tb;
  localparam int  W     = 16;
  localparam int  AW    = 16;
  localparam real PI    = 3.14159265358979323846;
  localparam real SCALE = 2.0 ** (W - 2);

  typedef struct {
    int ec;
    int es;
    int acc;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] angle_i = '0;
  logic [W-1:0]  cos_o;
  logic [W-1:0]  sin_o;
  logic          done_o;

  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  int   n_seen = 0;
  exp_t sb[$];

  cordic_rot #(.W(W), .AW(AW)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .angle_i(angle_i),
    .cos_o  (cos_o),
    .sin_o  (sin_o),
    .done_o (done_o)
  );

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int deg_code(input real d);
    return rnd(d * (2.0 ** AW) / 360.0);
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // monitor: pops one expected item per rising done
  initial begin
    logic done_d;
    exp_t e;
    int   c;
    int   s;
    done_d = 1'b0;
    forever begin
      @(negedge clk_i);
      if (done_o && !done_d) begin
        c = int'($signed(cos_o));
        s = int'($signed(sin_o));
        if (sb.size() == 0) begin
          chk(1'b0, "R2 unexpected done", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(cyc - e.acc == W, "R2 latency", cyc - e.acc, W);
          chk(iabs(c - e.ec) <= 2, "R3 cos", c, e.ec);
          chk(iabs(s - e.es) <= 2, "R3 sin", s, e.es);
          chk(iabs(c) <= 2 ** (W - 2) + 2 && iabs(s) <= 2 ** (W - 2) + 2, "R7 bound",
              (iabs(c) > iabs(s)) ? iabs(c) : iabs(s), 2 ** (W - 2) + 2);
        end
        n_seen++;
      end
      done_d = done_o;
    end
  end

  // driver: one computation, optionally with a stray start mid-run (R5)
  task automatic run_one(input int code, input bit poke, input int poke_code);
    exp_t e;
    bit   was_done;
    int   target;
    real  th;
    th   = real'(code) * 2.0 * PI / (2.0 ** AW);
    e.ec = rnd(SCALE * $cos(th));
    e.es = rnd(SCALE * $sin(th));
    target = n_seen + 1;
    @(negedge clk_i);
    was_done = done_o;
    start_i  = 1'b1;
    angle_i  = AW'(code);
    e.acc    = cyc + 1;
    sb.push_back(e);
    @(negedge clk_i);
    start_i = 1'b0;
    angle_i = AW'(code ^ 32'h5a5a);
    if (was_done) chk(done_o == 1'b0, "R6 restart clears done", int'(done_o), 0);
    if (poke) begin
      repeat (3) @(negedge clk_i);
      start_i = 1'b1;
      angle_i = AW'(poke_code);
      @(negedge clk_i);
      start_i = 1'b0;
      angle_i = AW'(~poke_code);
    end
    wait (n_seen == target);
  endtask

  initial begin
    int c0;
    int s0;
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
    chk(cos_o == '0, "R1 cos after reset", int'(cos_o), 0);
    chk(sin_o == '0, "R1 sin after reset", int'(sin_o), 0);

    // R3 corner angles
    run_one(0, 1'b0, 0);
    run_one(deg_code(30.0), 1'b0, 0);
    run_one(deg_code(-30.0), 1'b0, 0);
    run_one(deg_code(45.0), 1'b0, 0);
    run_one(deg_code(-45.0), 1'b0, 0);
    run_one(deg_code(90.0), 1'b0, 0);
    run_one(deg_code(-90.0), 1'b0, 0);
    run_one(deg_code(60.0), 1'b0, 0);
    run_one(deg_code(99.0), 1'b0, 0);
    run_one(deg_code(-99.0), 1'b0, 0);
    run_one(1, 1'b0, 0);

    // R4 hold without start
    c0 = int'(cos_o);
    s0 = int'(sin_o);
    repeat (W + 4) @(negedge clk_i);
    chk(done_o == 1'b1, "R4 done held", int'(done_o), 1);
    chk(int'(cos_o) == c0, "R4 cos held", int'(cos_o), c0);
    chk(int'(sin_o) == s0, "R4 sin held", int'(sin_o), s0);

    // R5 stray start and angle while busy
    run_one(deg_code(30.0), 1'b1, deg_code(-90.0));
    repeat (W + 4) @(negedge clk_i);
    chk(done_o == 1'b1, "R5 no second run", int'(done_o), 1);
    chk(sb.size() == 0, "R5 no extra result", sb.size(), 0);
    run_one(deg_code(-60.0), 1'b1, deg_code(75.0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_seen, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule